// File: doc/BRIEF.md
# Register Pointer Auto-Increment Controller

This block sits behind a serial-bus target and decides which register of an eighteen-entry register file (addresses 00h to 11h) each transferred data byte touches. The first write byte that follows a matched write address is taken as a control byte. Its upper three bits pick an increment mode and its lower five bits load the register pointer. Each later data byte, read or written, uses the current pointer. The pointer then either holds or steps forward inside a window chosen by the mode, and wraps at the window's upper edge.

The twelve registers that drive the LED outputs (02h to 0Dh) are kept twice. A shadow copy takes every accepted write. A live copy feeds the outputs and is loaded from the shadow either on the acknowledge of each write or all at once when the bus stop arrives. The choice follows a mode input, and the default is to commit at stop. While the sleep flag is set, every write is refused except a write to register 00h, so that software can still clear sleep.

Byte events arrive as a valid/ready stream. `byte_ready` is always high, so the block never applies back-pressure: each cycle with `byte_valid` high is one completed byte. Start, stop and the address-match indication are single-cycle control pulses.

Top module: `regptr_ai_ctrl`

## Requirements
- R1: The first byte with `byte_valid`=1 and `byte_rd`=0 after a `sel_write` pulse (with no `bus_start` in between) is the control byte. Bits 7:5 appear on `ai_mode` and bits 4:0 on `reg_ptr` one cycle later, and no write strobe is produced for it.
- R2: With `ai_mode` 000, or any of the reserved codes 001, 010 and 011, `reg_ptr` does not change after a data byte.
- R3: With `ai_mode` 100 the pointer steps by one after each data byte, and goes from 11h to 00h.
- R4: With `ai_mode` 101 the pointer wraps from 09h to 02h. With 110 it wraps from 0Bh to 0Ah. With 111 it wraps from 0Bh to 02h.
- R5: In modes 101, 110 and 111, a pointer above the window's upper edge counts up to 11h and then goes to the window's lower edge. A pointer below the window counts up into it.
- R6: An accepted write byte raises `wr_en` for one cycle, one cycle after the byte. `wr_addr` carries the pointer the byte used and `wr_data` carries the byte.
- R7: With `commit_on_ack`=0, writes to 02h..0Dh change only the shadow copy. One cycle after `bus_stop`, `led_cfg` takes the shadow and `commit_pulse` rises for one cycle. A stop with no pending write gives no pulse.
- R8: With `commit_on_ack`=1, a write to 02h..0Dh updates `led_cfg` and pulses `commit_pulse` one cycle after the byte. `led_cfg` never changes without `commit_pulse`.
- R9: While `sleep`=1, writes to any register other than 00h produce no strobe and leave `led_cfg` unchanged. The pointer still advances.
- R10: When `reg_ptr` is above 11h, `rd_addr` is 00h and writes are discarded.
- R11: After reset, `reg_ptr`=0, `ai_mode`=0, no strobes, and `led_cfg` holds 0 in every byte except byte 8 (register 0Ah), which holds FFh. Byte i of `led_cfg` is register 02h+i.
- R12: Read bytes (`byte_rd`=1) advance the pointer by the same rules as writes and never load the control byte.
- R13: `byte_ready` is 1 out of reset, and every valid byte is consumed in its own cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_start | input | 1 | Start condition pulse; cancels a pending control byte |
| bus_stop | input | 1 | Stop condition pulse |
| sel_write | input | 1 | Pulse: own address matched with write direction |
| byte_valid | input | 1 | A data byte completed this cycle |
| byte_ready | output | 1 | Always high; no back-pressure |
| byte_rd | input | 1 | The completed byte was a read |
| byte_data | input | 8 | Written byte value |
| sleep | input | 1 | Sleep flag; blocks writes except to 00h |
| commit_on_ack | input | 1 | 1: commit per write; 0: commit at stop |
| reg_ptr | output | 5 | Current register pointer |
| rd_addr | output | 5 | Register to read; 00h when pointer is above 11h |
| ai_mode | output | 3 | Increment mode mirror |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | 5 | Register written |
| wr_data | output | 8 | Value written |
| commit_pulse | output | 1 | Live output copy was loaded |
| led_cfg | output | 96 | Live copy of registers 02h..0Dh, byte i = register 02h+i |

## Verification
On every cycle the assertions check that strobes only target legal addresses, that a sleeping block writes only register 00h, that the live copy never moves without a commit pulse, and that stop-mode commits only follow a stop. They also check that non-incrementing modes hold the pointer and that the group window stays closed. Exact wrap sequences per mode, the climb from above the window, the dropping of the control byte as data, and the shadow contents committed at stop need the bench's scenarios, where a reference model follows each byte.

// File: rtl/regptr_pkg.sv
package regptr_pkg;

  localparam int unsigned PTR_W = 5;
  localparam logic [PTR_W-1:0] LAST_REG = 5'h11;

  // increment mode codes (control byte bits 7:5)
  localparam logic [2:0] AI_NONE   = 3'b000;
  localparam logic [2:0] AI_ALL    = 3'b100;
  localparam logic [2:0] AI_BRIGHT = 3'b101;
  localparam logic [2:0] AI_GROUP  = 3'b110;
  localparam logic [2:0] AI_BOTH   = 3'b111;

  function automatic logic [PTR_W-1:0] win_lo(input logic [2:0] ai);
    case (ai)
      AI_BRIGHT, AI_BOTH: win_lo = 5'h02;
      AI_GROUP:           win_lo = 5'h0A;
      default:            win_lo = 5'h00;
    endcase
  endfunction

  function automatic logic [PTR_W-1:0] win_hi(input logic [2:0] ai);
    case (ai)
      AI_BRIGHT:          win_hi = 5'h09;
      AI_GROUP, AI_BOTH:  win_hi = 5'h0B;
      default:            win_hi = LAST_REG;
    endcase
  endfunction

  // reserved codes have bit 2 clear and act as no increment
  function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p,
                                                input logic [2:0] ai);
    if (!ai[2])                                 step_ptr = p;
    else if (p == win_hi(ai) || p >= LAST_REG)  step_ptr = win_lo(ai);
    else                                        step_ptr = p + 1'b1;
  endfunction

endpackage

// File: rtl/regptr_ctl_seq.sv
module regptr_ctl_seq
  import regptr_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_start,
  input  logic              sel_write,
  input  logic              byte_fire,
  input  logic              byte_rd,
  input  logic [DATA_W-1:0] byte_data,
  output logic [PTR_W-1:0]  ptr_q,
  output logic [2:0]        ai_q,
  output logic              data_fire
);

  logic expect_ctrl_q;
  logic ctrl_fire;

  assign ctrl_fire = byte_fire & expect_ctrl_q & ~byte_rd;
  assign data_fire = byte_fire & ~ctrl_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      expect_ctrl_q <= 1'b0;
      ptr_q         <= '0;
      ai_q          <= AI_NONE;
    end else begin
      if (ctrl_fire) begin
        ai_q          <= byte_data[DATA_W-1 -: 3];
        ptr_q         <= byte_data[PTR_W-1:0];
        expect_ctrl_q <= 1'b0;
      end else if (data_fire) begin
        ptr_q <= step_ptr(ptr_q, ai_q);
      end
      if (bus_start) expect_ctrl_q <= 1'b0;
      if (sel_write) expect_ctrl_q <= 1'b1;
    end
  end

endmodule

// File: rtl/regptr_wr_gate.sv
module regptr_wr_gate
  import regptr_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_fire,
  input  logic              byte_rd,
  input  logic [DATA_W-1:0] byte_data,
  input  logic [PTR_W-1:0]  ptr,
  input  logic              sleep,
  output logic              wr_ok,
  output logic              wr_en,
  output logic [PTR_W-1:0]  wr_addr,
  output logic [DATA_W-1:0] wr_data
);

  logic in_range;
  logic sleep_pass;

  assign in_range   = (ptr <= LAST_REG);
  assign sleep_pass = ~sleep | (ptr == '0);
  assign wr_ok      = data_fire & ~byte_rd & in_range & sleep_pass;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= wr_ok;
      if (wr_ok) begin
        wr_addr <= ptr;
        wr_data <= byte_data;
      end
    end
  end

endmodule

// File: rtl/regptr_shadow_bank.sv
module regptr_shadow_bank
  import regptr_pkg::*;
#(
  parameter int unsigned     DATA_W    = 8,
  parameter logic [PTR_W-1:0] OUT_FIRST = 5'h02,
  parameter logic [PTR_W-1:0] OUT_LAST  = 5'h0D,
  parameter logic [PTR_W-1:0] FULL_REG  = 5'h0A,
  localparam int unsigned    NUM_OUT   = int'(OUT_LAST) - int'(OUT_FIRST) + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_ok,
  input  logic [PTR_W-1:0]          ptr,
  input  logic [DATA_W-1:0]         byte_data,
  input  logic                      commit_on_ack,
  input  logic                      bus_stop,
  output logic                      commit_pulse,
  output logic [NUM_OUT*DATA_W-1:0] live_flat
);

  logic [NUM_OUT-1:0]  hit;
  logic [DATA_W-1:0]   shadow_q   [NUM_OUT];
  logic [DATA_W-1:0]   shadow_nxt [NUM_OUT];
  logic [DATA_W-1:0]   live_q     [NUM_OUT];
  logic                pending_q;
  logic                any_hit;
  logic                load_live;

  assign any_hit   = |hit;
  assign load_live = (any_hit & commit_on_ack) | (bus_stop & (pending_q | any_hit));

  for (genvar gi = 0; gi < NUM_OUT; gi++) begin : g_reg
    localparam logic [PTR_W-1:0] ADDR = OUT_FIRST + PTR_W'(gi);
    localparam logic [DATA_W-1:0] RST = (ADDR == FULL_REG) ? '1 : '0;

    assign hit[gi]        = wr_ok & (ptr == ADDR);
    assign shadow_nxt[gi] = hit[gi] ? byte_data : shadow_q[gi];
    assign live_flat[gi*DATA_W +: DATA_W] = live_q[gi];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shadow_q[gi] <= RST;
        live_q[gi]   <= RST;
      end else begin
        shadow_q[gi] <= shadow_nxt[gi];
        if (load_live) live_q[gi] <= shadow_nxt[gi];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q    <= 1'b0;
      commit_pulse <= 1'b0;
    end else begin
      commit_pulse <= load_live;
      if (load_live)    pending_q <= 1'b0;
      else if (any_hit) pending_q <= 1'b1;
    end
  end

endmodule

// File: rtl/regptr_ai_ctrl.sv
module regptr_ai_ctrl
  import regptr_pkg::*;
#(
  parameter int unsigned      DATA_W    = 8,
  parameter logic [4:0]       OUT_FIRST = 5'h02,
  parameter logic [4:0]       OUT_LAST  = 5'h0D,
  parameter logic [4:0]       FULL_REG  = 5'h0A
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_start,
  input  logic                 bus_stop,
  input  logic                 sel_write,
  input  logic                 byte_valid,
  output logic                 byte_ready,
  input  logic                 byte_rd,
  input  logic [DATA_W-1:0]    byte_data,
  input  logic                 sleep,
  input  logic                 commit_on_ack,
  output logic [4:0]           reg_ptr,
  output logic [4:0]           rd_addr,
  output logic [2:0]           ai_mode,
  output logic                 wr_en,
  output logic [4:0]           wr_addr,
  output logic [DATA_W-1:0]    wr_data,
  output logic                 commit_pulse,
  output logic [(int'(OUT_LAST)-int'(OUT_FIRST)+1)*DATA_W-1:0] led_cfg
);

  logic byte_fire;
  logic data_fire;
  logic wr_ok;

  assign byte_ready = 1'b1;
  assign byte_fire  = byte_valid & byte_ready;
  assign rd_addr    = (reg_ptr > LAST_REG) ? '0 : reg_ptr;

  regptr_ctl_seq #(.DATA_W(DATA_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_start (bus_start),
    .sel_write (sel_write),
    .byte_fire (byte_fire),
    .byte_rd   (byte_rd),
    .byte_data (byte_data),
    .ptr_q     (reg_ptr),
    .ai_q      (ai_mode),
    .data_fire (data_fire)
  );

  regptr_wr_gate #(.DATA_W(DATA_W)) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .data_fire (data_fire),
    .byte_rd   (byte_rd),
    .byte_data (byte_data),
    .ptr       (reg_ptr),
    .sleep     (sleep),
    .wr_ok     (wr_ok),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data)
  );

  regptr_shadow_bank #(
    .DATA_W    (DATA_W),
    .OUT_FIRST (OUT_FIRST),
    .OUT_LAST  (OUT_LAST),
    .FULL_REG  (FULL_REG)
  ) u_bank (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_ok         (wr_ok),
    .ptr           (reg_ptr),
    .byte_data     (byte_data),
    .commit_on_ack (commit_on_ack),
    .bus_stop      (bus_stop),
    .commit_pulse  (commit_pulse),
    .live_flat     (led_cfg)
  );

endmodule

// File: rtl/regptr_ai_ctrl_chk.sv
module regptr_ai_ctrl_chk #(
  parameter int unsigned LW = 96
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_start,
  input logic          bus_stop,
  input logic          sel_write,
  input logic          byte_valid,
  input logic          byte_rd,
  input logic          sleep,
  input logic          commit_on_ack,
  input logic [4:0]    reg_ptr,
  input logic [2:0]    ai_mode,
  input logic          wr_en,
  input logic [4:0]    wr_addr,
  input logic          commit_pulse,
  input logic [LW-1:0] led_cfg
);

  // R1: control byte after a write match never becomes a register write
  a_r1_ctrl_not_written: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && !byte_rd && $past(sel_write) && !$past(bus_start) && !$past(byte_valid))
      |=> !wr_en);

  // R2: non-incrementing and reserved modes hold the pointer on reads
  a_r2_hold_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && byte_rd && !ai_mode[2]) |=> $stable(reg_ptr));

  // R4: group window stays inside 0Ah..0Bh
  a_r4_group_window: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && byte_rd && ai_mode == 3'b110 && (reg_ptr == 5'h0A || reg_ptr == 5'h0B))
      |=> (reg_ptr == 5'h0A || reg_ptr == 5'h0B));

  // R6: a strobe only follows a written byte
  a_r6_strobe_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(byte_valid && !byte_rd));

  // R7: in stop mode a commit only follows a stop
  a_r7_stop_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_pulse && !$past(commit_on_ack)) |-> $past(bus_stop));

  // R8: live copy changes only together with a commit pulse
  a_r8_live_needs_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(led_cfg) |-> commit_pulse);

  // R9: while asleep only register 00h is written
  a_r9_sleep_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(sleep)) |-> (wr_addr == 5'h00));

  // R10: no strobe targets an address past 11h
  a_r10_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_addr <= 5'h11));

endmodule

bind regptr_ai_ctrl regptr_ai_ctrl_chk #(.LW($bits(led_cfg))) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_start     (bus_start),
  .bus_stop      (bus_stop),
  .sel_write     (sel_write),
  .byte_valid    (byte_valid),
  .byte_rd       (byte_rd),
  .sleep         (sleep),
  .commit_on_ack (commit_on_ack),
  .reg_ptr       (reg_ptr),
  .ai_mode       (ai_mode),
  .wr_en         (wr_en),
  .wr_addr       (wr_addr),
  .commit_pulse  (commit_pulse),
  .led_cfg       (led_cfg)
);

// File: tb/regptr_ai_ctrl_tb.sv
module regptr_ai_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_start = 1'b0, bus_stop = 1'b0, sel_write = 1'b0;
  logic        byte_valid = 1'b0, byte_rd = 1'b0;
  logic [7:0]  byte_data = 8'h00;
  logic        sleep = 1'b0, commit_on_ack = 1'b0;
  logic        byte_ready;
  logic [4:0]  reg_ptr, rd_addr, wr_addr;
  logic [2:0]  ai_mode;
  logic        wr_en, commit_pulse;
  logic [7:0]  wr_data;
  logic [95:0] led_cfg;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  logic [4:0] m_ptr;
  logic [2:0] m_ai;
  bit         m_expect, m_pend, e_wr, e_commit;
  logic [4:0] e_wa;
  logic [7:0] e_wd;
  logic [7:0] m_sh [12];
  logic [7:0] m_live [12];

  always #2 clk = ~clk;

  regptr_ai_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
    .sel_write(sel_write), .byte_valid(byte_valid), .byte_ready(byte_ready),
    .byte_rd(byte_rd), .byte_data(byte_data), .sleep(sleep),
    .commit_on_ack(commit_on_ack), .reg_ptr(reg_ptr), .rd_addr(rd_addr),
    .ai_mode(ai_mode), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .commit_pulse(commit_pulse), .led_cfg(led_cfg)
  );

  function automatic logic [4:0] f_next(input logic [4:0] p, input logic [2:0] ai);
    logic [4:0] lo, hi;
    lo = (ai == 3'b110) ? 5'h0A : ((ai == 3'b101 || ai == 3'b111) ? 5'h02 : 5'h00);
    hi = (ai == 3'b101) ? 5'h09 : ((ai == 3'b110 || ai == 3'b111) ? 5'h0B : 5'h11);
    if (ai inside {3'b000, 3'b001, 3'b010, 3'b011}) return p;
    if (p == hi || p >= 5'h11) return lo;
    return p + 5'd1;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk("R13", "ready", int'(byte_ready), 1);
    chk(tag, "ptr", int'(reg_ptr), int'(m_ptr));
    chk("R1", "ai_mode", int'(ai_mode), int'(m_ai));
    chk("R10", "rd_addr", int'(rd_addr), (m_ptr > 5'h11) ? 0 : int'(m_ptr));
    chk("R6", "wr_en", int'(wr_en), int'(e_wr));
    if (e_wr) begin
      chk("R6", "wr_addr", int'(wr_addr), int'(e_wa));
      chk("R6", "wr_data", int'(wr_data), int'(e_wd));
    end
    chk("R7", "commit", int'(commit_pulse), int'(e_commit));
    for (int i = 0; i < 12; i++)
      chk("R8", "led_cfg byte", int'(led_cfg[i*8 +: 8]), int'(m_live[i]));
  endtask

  // drive one cycle of inputs, update the reference, check after the edge
  task automatic step(input string tag, input bit st, input bit sp, input bit sw,
                      input bit bv, input bit rd, input logic [7:0] d);
    bit hit;
    bus_start = st; bus_stop = sp; sel_write = sw;
    byte_valid = bv; byte_rd = rd; byte_data = d;
    @(posedge clk);
    hit = 0; e_wr = 0; e_commit = 0;
    if (bv) begin
      if (m_expect && !rd) begin
        m_ai = d[7:5]; m_ptr = d[4:0]; m_expect = 0;
      end else begin
        if (!rd && m_ptr <= 5'h11 && (!sleep || m_ptr == 5'h00)) begin
          e_wr = 1; e_wa = m_ptr; e_wd = d;
          if (m_ptr >= 5'h02 && m_ptr <= 5'h0D) begin
            m_sh[m_ptr - 5'h02] = d; hit = 1;
          end
        end
        m_ptr = f_next(m_ptr, m_ai);
      end
    end
    if ((hit && commit_on_ack) || (sp && (m_pend || hit))) begin
      for (int i = 0; i < 12; i++) m_live[i] = m_sh[i];
      e_commit = 1; m_pend = 0;
    end else if (hit) m_pend = 1;
    if (st) m_expect = 0;
    if (sw) m_expect = 1;
    @(negedge clk);
    bus_start = 0; bus_stop = 0; sel_write = 0; byte_valid = 0; byte_rd = 0;
    compare(tag);
  endtask

  task automatic open_write(input string tag, input logic [7:0] ctrl);
    step(tag, 1, 0, 0, 0, 0, 8'h00);
    step(tag, 0, 0, 1, 0, 0, 8'h00);
    step(tag, 0, 0, 0, 1, 0, ctrl);
  endtask

  task automatic wbyte(input string tag, input logic [7:0] d);
    step(tag, 0, 0, 0, 1, 0, d);
  endtask

  task automatic rbyte(input string tag);
    step(tag, 0, 0, 0, 1, 1, 8'h00);
  endtask

  task automatic close(input string tag);
    step(tag, 0, 1, 0, 0, 0, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd1049;
    void'($urandom(seed));
    m_ptr = 0; m_ai = 0; m_expect = 0; m_pend = 0; e_wr = 0; e_commit = 0;
    e_wa = 0; e_wd = 0;
    for (int i = 0; i < 12; i++) begin
      m_sh[i] = (i == 8) ? 8'hFF : 8'h00;
      m_live[i] = m_sh[i];
    end
    repeat (3) @(negedge clk);
    compare("R11");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R11");

    // R1 control byte capture, then R5 climb above the 111 window
    open_write("R1", 8'hEC);
    for (int i = 0; i < 8; i++) wbyte("R5", 8'h10 + 8'(i));
    close("R7");

    // R3 full range wrap
    open_write("R3", 8'h90);
    for (int i = 0; i < 3; i++) wbyte("R3", 8'h20 + 8'(i));
    close("R3");

    // R4 brightness and group windows
    open_write("R4", 8'hA8);
    for (int i = 0; i < 4; i++) wbyte("R4", 8'h30 + 8'(i));
    close("R4");
    open_write("R4", 8'hCB);
    for (int i = 0; i < 4; i++) rbyte("R4");
    close("R4");

    // R2 no increment and a reserved code
    open_write("R2", 8'h05);
    wbyte("R2", 8'h41); wbyte("R2", 8'h42);
    close("R2");
    open_write("R2", 8'h43);
    rbyte("R2"); wbyte("R2", 8'h44);
    close("R2");

    // R7 stop with nothing pending gives no pulse
    step("R7", 1, 0, 0, 0, 0, 8'h00);
    close("R7");

    // R8 commit per acknowledged write
    commit_on_ack = 1'b1;
    open_write("R8", 8'hA2);
    for (int i = 0; i < 3; i++) wbyte("R8", 8'h50 + 8'(i));
    close("R8");
    commit_on_ack = 1'b0;

    // R9 sleep blocks all but register 00h
    sleep = 1'b1;
    open_write("R9", 8'h84);
    wbyte("R9", 8'h66);
    close("R9");
    open_write("R9", 8'h00);
    wbyte("R9", 8'h01);
    close("R9");
    sleep = 1'b0;

    // R10 pointer beyond the file
    open_write("R10", 8'h15);
    wbyte("R10", 8'h77); rbyte("R10");
    close("R10");

    // R12 read session without a control byte
    step("R12", 1, 0, 0, 0, 0, 8'h00);
    open_write("R12", 8'hE2);
    close("R12");
    step("R12", 1, 0, 0, 0, 0, 8'h00);
    for (int i = 0; i < 12; i++) rbyte("R12");
    close("R12");

    // random sessions
    for (int s = 0; s < 300; s++) begin
      int n;
      commit_on_ack = ($urandom % 3) == 0;
      sleep = ($urandom % 8) == 0;
      n = 1 + ($urandom % 10);
      if (($urandom % 4) != 0) open_write("R12", 8'($urandom));
      else step("R12", 1, 0, 0, 0, 0, 8'h00);
      for (int k = 0; k < n; k++) begin
        if (($urandom % 4) == 0) rbyte("R12");
        else wbyte("R6", 8'($urandom));
      end
      close("R7");
    end
    sleep = 1'b0;

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule